// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block models a byte-wide static RAM with a shadow nonvolatile array behind it, and manages copies between the two. A STORE copies the whole SRAM into the shadow array. It starts in one of two ways. The first is a low-supply comparator input. The second is an external request on an active-low open-drain handshake line. A RECALL first clears the SRAM and then loads it from the shadow array. A RECALL request is held from reset, and is also set after any low-supply event. It runs once the supply is reported good and no longer low.

The handshake line is used in both directions. The controller pulls it low for the whole of every STORE. After the STORE it keeps the device disabled until it sees the line high again. Before the copy starts, a host SRAM access that is still in progress gets a bounded window to finish. Host reads and writes are accepted only while the device is enabled. Every delay is a parameter counted in clock cycles.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset, dev_en_o, busy_o and hs_drive_o are all 0. The device stays disabled until sup_ok_i is 1 and sup_low_i is 0 at a clock edge.
- R2: A RECALL keeps busy_o at 1 for exactly 2*DEPTH+1 cycles: DEPTH cycles clearing the SRAM, then DEPTH+1 cycles loading it from the shadow array. After that, dev_en_o becomes 1.
- R3: When sup_low_i is 1 at an edge while the device is enabled, a STORE begins. From the next cycle, busy_o and hs_drive_o are 1 and dev_en_o is 0.
- R4: hs_drive_o (1 means the line is pulled low) stays 1 for every cycle of a STORE, including the access window. It returns to 0 when the copy ends.
- R5: The copy starts at the first edge where host_busy_i is 0, or after DRAIN_CYC cycles, whichever comes first. The copy then lasts DEPTH+1 cycles.
- R6: While the device is enabled, a STORE starts if the synchronised hs_i stays low for MIN_PULSE consecutive cycles. busy_o rises no more than MIN_PULSE+3 cycles after hs_i falls. A shorter low pulse has no effect.
- R7: After a STORE, dev_en_o stays 0 until the synchronised hs_i reads 1. If sup_low_i was 1 at any time during or just before that STORE, the device then waits for a RECALL (as in R1) instead of being enabled.
- R8: While dev_en_o is 0, host writes are ignored and do not change the SRAM.
- R9: A hardware request made while a STORE is running, including a line held low for its whole length, does not cause a second STORE.
- R10: Only a STORE writes the shadow array. A RECALL, whether after reset or after low supply, restores the data saved by the last STORE and leaves the shadow array unchanged.
- R11: A STORE holds hs_drive_o for no more than STORE_LIMIT cycles. A RECALL holds busy_o for no more than RCL_LIMIT cycles.
- R12: When the device is enabled, a host write with host_en_i=1 and host_we_i=1 stores host_wdata_i at host_addr_i. A read with host_en_i=1 and host_we_i=0 presents that word on host_rdata_o in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_low_i | input | 1 | Supply below the switch threshold |
| sup_ok_i | input | 1 | Supply good for recall |
| host_busy_i | input | 1 | An SRAM access is still in progress |
| hs_i | input | 1 | Sensed level of the handshake line |
| hs_drive_o | output | 1 | 1 pulls the handshake line low |
| dev_en_o | output | 1 | Device enabled for host access |
| busy_o | output | 1 | STORE or RECALL in progress |
| host_en_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | $clog2(DEPTH) | Host word address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Host read data, valid the cycle after a read |

## Verification
The hardest situation to reach is a hardware request that overlaps a STORE which the controller is already driving. On the line, the external pull and the controller's own pull look the same. The bench holds its external pull low from before the STORE until well after the copy ends. It then checks three things: the device stays disabled past the end of the copy, it re-enables only after the bench releases the line, and no second busy period follows. A host write attempted during that STORE is later read back to confirm it was dropped.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    PH_RWAIT   = 3'd0,
    PH_RCLR    = 3'd1,
    PH_RXFER   = 3'd2,
    PH_IDLE    = 3'd3,
    PH_DRAIN   = 3'd4,
    PH_STORE   = 3'd5,
    PH_RELEASE = 3'd6
  } nvs_phase_t;
endpackage

// File: rtl/nvs_spram.sv
module nvs_spram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first single port, block RAM friendly
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= d;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/nvs_hsdet.sv
module nvs_hsdet #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic en_i,
  output logic line_s_o,
  output logic req_o
);
  localparam int LW = $clog2(MIN_PULSE + 1);

  logic          s1, s2;
  logic [LW-1:0] lowcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
    end
  end

  // consecutive synchronised low cycles, counted only while enabled
  always_ff @(posedge clk) begin
    if (rst || !en_i || s2) lowcnt <= '0;
    else if (lowcnt != LW'(MIN_PULSE)) lowcnt <= lowcnt + 1'b1;
  end

  assign line_s_o = s2;
  assign req_o    = en_i && !s2 && (lowcnt == LW'(MIN_PULSE - 1));
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int DRAIN_CYC = 250,
  parameter int CW        = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sup_low_i,
  input  logic          sup_ok_i,
  input  logic          host_busy_i,
  input  logic          line_s_i,
  input  logic          hw_req_i,
  output nvs_phase_t    phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          dev_en_o,
  output logic          busy_o,
  output logic          drive_o
);
  localparam int DCW = $clog2(DRAIN_CYC + 1);

  nvs_phase_t     ph, ph_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic [DCW-1:0] dcnt, dcnt_n;
  logic           pend, pend_n;
  logic           in_store_path;

  assign in_store_path = (ph == PH_IDLE) || (ph == PH_DRAIN) ||
                         (ph == PH_STORE) || (ph == PH_RELEASE);

  always_comb begin
    ph_n   = ph;
    cnt_n  = cnt;
    dcnt_n = dcnt;
    case (ph)
      PH_RWAIT: begin
        if (sup_ok_i && !sup_low_i) begin
          ph_n  = PH_RCLR;
          cnt_n = '0;
        end
      end
      PH_RCLR: begin
        if (cnt == CW'(DEPTH - 1)) begin
          ph_n  = PH_RXFER;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      PH_RXFER: begin
        if (cnt == CW'(DEPTH)) begin
          ph_n  = PH_IDLE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      PH_IDLE: begin
        if (sup_low_i || hw_req_i) begin
          ph_n   = PH_DRAIN;
          dcnt_n = '0;
        end
      end
      PH_DRAIN: begin
        if (!host_busy_i || dcnt == DCW'(DRAIN_CYC - 1)) begin
          ph_n  = PH_STORE;
          cnt_n = '0;
        end else begin
          dcnt_n = dcnt + 1'b1;
        end
      end
      PH_STORE: begin
        if (cnt == CW'(DEPTH)) begin
          ph_n  = PH_RELEASE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      PH_RELEASE: begin
        if (line_s_i) ph_n = pend ? PH_RWAIT : PH_IDLE;
      end
      default: ph_n = PH_RWAIT;
    endcase
  end

  // low-supply memory: any low-supply sighting on the store path arms a recall
  always_comb begin
    pend_n = pend;
    if (ph == PH_RELEASE && ph_n == PH_RWAIT) pend_n = 1'b0;
    else if (in_store_path)                   pend_n = pend | sup_low_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_RWAIT;
      cnt      <= '0;
      dcnt     <= '0;
      pend     <= 1'b0;
      dev_en_o <= 1'b0;
      busy_o   <= 1'b0;
      drive_o  <= 1'b0;
    end else begin
      ph       <= ph_n;
      cnt      <= cnt_n;
      dcnt     <= dcnt_n;
      pend     <= pend_n;
      dev_en_o <= (ph_n == PH_IDLE);
      busy_o   <= (ph_n == PH_RCLR) || (ph_n == PH_RXFER) ||
                  (ph_n == PH_DRAIN) || (ph_n == PH_STORE);
      drive_o  <= (ph_n == PH_DRAIN) || (ph_n == PH_STORE);
    end
  end

  assign phase_o = ph;
  assign cnt_o   = cnt;
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DEPTH       = 256,
  parameter int DRAIN_CYC   = 250,
  parameter int MIN_PULSE   = 4,
  parameter int STORE_LIMIT = DRAIN_CYC + DEPTH + 1,
  parameter int RCL_LIMIT   = 2 * DEPTH + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sup_low_i,
  input  logic                     sup_ok_i,
  input  logic                     host_busy_i,
  input  logic                     hs_i,
  output logic                     hs_drive_o,
  output logic                     dev_en_o,
  output logic                     busy_o,
  input  logic                     host_en_i,
  input  logic                     host_we_i,
  input  logic [$clog2(DEPTH)-1:0] host_addr_i,
  input  logic [DW-1:0]            host_wdata_i,
  output logic [DW-1:0]            host_rdata_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  nvs_phase_t    phase;
  logic [CW-1:0] cnt;
  logic [AW-1:0] cnt_a, cnt_m1;
  logic          cnt_live;
  logic          line_s, hw_req;

  logic          sram_en, sram_we, sh_en, sh_we;
  logic [AW-1:0] sram_a, sh_a;
  logic [DW-1:0] sram_d, sram_q, sh_d, sh_q;

  nvs_hsdet #(.MIN_PULSE(MIN_PULSE)) u_hs (
    .clk      (clk),
    .rst      (rst),
    .line_i   (hs_i),
    .en_i     (phase == PH_IDLE),
    .line_s_o (line_s),
    .req_o    (hw_req)
  );

  nvs_seq #(.DEPTH(DEPTH), .DRAIN_CYC(DRAIN_CYC), .CW(CW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .sup_low_i   (sup_low_i),
    .sup_ok_i    (sup_ok_i),
    .host_busy_i (host_busy_i),
    .line_s_i    (line_s),
    .hw_req_i    (hw_req),
    .phase_o     (phase),
    .cnt_o       (cnt),
    .dev_en_o    (dev_en_o),
    .busy_o      (busy_o),
    .drive_o     (hs_drive_o)
  );

  assign cnt_a    = cnt[AW-1:0];
  assign cnt_m1   = AW'(cnt - 1'b1);
  assign cnt_live = (cnt < CW'(DEPTH));

  // port steering: host in IDLE, copy engine in the copy phases
  always_comb begin
    sram_en = 1'b0;
    sram_we = 1'b0;
    sram_a  = host_addr_i;
    sram_d  = host_wdata_i;
    sh_en   = 1'b0;
    sh_we   = 1'b0;
    sh_a    = cnt_a;
    sh_d    = sram_q;
    case (phase)
      PH_IDLE: begin
        sram_en = host_en_i;
        sram_we = host_en_i && host_we_i;
      end
      PH_RCLR: begin
        sram_en = 1'b1;
        sram_we = 1'b1;
        sram_a  = cnt_a;
        sram_d  = '0;
      end
      PH_RXFER: begin
        sh_en   = cnt_live;
        sh_a    = cnt_a;
        sram_en = (cnt != '0);
        sram_we = (cnt != '0);
        sram_a  = cnt_m1;
        sram_d  = sh_q;
      end
      PH_STORE: begin
        sram_en = cnt_live;
        sram_a  = cnt_a;
        sh_en   = (cnt != '0);
        sh_we   = (cnt != '0);
        sh_a    = cnt_m1;
        sh_d    = sram_q;
      end
      default: ;
    endcase
  end

  nvs_spram #(.AW(AW), .DW(DW)) u_sram (
    .clk (clk), .en (sram_en), .we (sram_we),
    .addr(sram_a), .d (sram_d), .q (sram_q)
  );

  nvs_spram #(.AW(AW), .DW(DW)) u_shadow (
    .clk (clk), .en (sh_en), .we (sh_we),
    .addr(sh_a), .d (sh_d), .q (sh_q)
  );

  assign host_rdata_o = sram_q;
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk #(
  parameter int STORE_LIMIT = 8,
  parameter int RCL_LIMIT   = 8
) (
  input logic clk,
  input logic rst,
  input logic sup_low_i,
  input logic dev_en_o,
  input logic busy_o,
  input logic hs_drive_o,
  input logic sram_we,
  input logic sh_we
);
  int drive_run;
  int rcl_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_run <= 0;
      rcl_run   <= 0;
    end else begin
      drive_run <= hs_drive_o ? drive_run + 1 : 0;
      rcl_run   <= (busy_o && !hs_drive_o) ? rcl_run + 1 : 0;
    end
  end

  AST_STORE_ON_LOW_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    (dev_en_o && sup_low_i) |=> (hs_drive_o && busy_o && !dev_en_o)); // R3
  AST_NO_ENABLE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_drive_o) |-> !dev_en_o); // R7
  AST_SHADOW_WRITE_IN_STORE: assert property (@(posedge clk) disable iff (rst)
    sh_we |-> (hs_drive_o && busy_o)); // R10
  AST_NO_HOST_WRITE_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (sram_we && !dev_en_o) |-> (busy_o && !hs_drive_o)); // R8
  AST_STORE_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    drive_run <= STORE_LIMIT); // R11
  AST_RECALL_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    rcl_run <= RCL_LIMIT); // R11
endmodule

bind nvs_ctrl nvs_ctrl_chk #(.STORE_LIMIT(STORE_LIMIT), .RCL_LIMIT(RCL_LIMIT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sup_low_i  (sup_low_i),
  .dev_en_o   (dev_en_o),
  .busy_o     (busy_o),
  .hs_drive_o (hs_drive_o),
  .sram_we    (sram_we),
  .sh_we      (sh_we)
);

// File: tb/sim_nvs_ctrl.sv
`timescale 1ns/1ps
module sim_nvs_ctrl;
  localparam int DW = 8, DEPTH = 16, AW = 4, DRAIN = 5, MINP = 3;
  localparam int STORE_LIM = DRAIN + DEPTH + 1, RCL_LIM = 2 * DEPTH + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic sup_low = 1'b0, sup_ok = 1'b0, host_busy = 1'b0, ext_low = 1'b0;
  logic host_en = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic hs_drive_o, dev_en_o, busy_o;
  logic [DW-1:0] host_rdata_o;
  logic hs_line;

  assign hs_line = !(hs_drive_o || ext_low);
  always #2 clk = ~clk;

  nvs_ctrl #(.DW(DW), .DEPTH(DEPTH), .DRAIN_CYC(DRAIN), .MIN_PULSE(MINP)) u0 (
    .clk(clk), .rst(rst), .sup_low_i(sup_low), .sup_ok_i(sup_ok),
    .host_busy_i(host_busy), .hs_i(hs_line), .hs_drive_o(hs_drive_o),
    .dev_en_o(dev_en_o), .busy_o(busy_o), .host_en_i(host_en), .host_we_i(host_we),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata_o));

  int checks = 0, errors = 0;
  bit done = 0, cmp_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase codes and cycle counts
  localparam int M_RW = 0, M_RC = 1, M_RX = 2, M_ID = 3, M_DR = 4, M_ST = 5, M_RL = 6;
  int m_ph, m_t, m_lc;
  bit m_s1, m_s2, m_pend;

  always @(posedge clk) begin
    int np;
    bit req, ln;
    if (rst) begin
      m_ph = M_RW; m_t = 0; m_lc = 0; m_s1 = 1; m_s2 = 1; m_pend = 0;
    end else begin
      ln  = hs_line;
      req = (m_ph == M_ID) && !m_s2 && (m_lc == MINP - 1);
      np  = m_ph;
      case (m_ph)
        M_RW: if (sup_ok && !sup_low) begin np = M_RC; m_t = 0; end
        M_RC: begin m_t++; if (m_t == DEPTH) begin np = M_RX; m_t = 0; end end
        M_RX: begin m_t++; if (m_t == DEPTH + 1) begin np = M_ID; m_t = 0; end end
        M_ID: if (sup_low || req) begin np = M_DR; m_t = 0; end
        M_DR: begin m_t++; if (!host_busy || m_t == DRAIN) begin np = M_ST; m_t = 0; end end
        M_ST: begin m_t++; if (m_t == DEPTH + 1) begin np = M_RL; m_t = 0; end end
        default: if (m_s2) np = m_pend ? M_RW : M_ID;
      endcase
      if (m_ph == M_RL && np == M_RW) m_pend = 0;
      else if (m_ph >= M_ID) m_pend = m_pend | sup_low;
      if (m_ph != M_ID || m_s2) m_lc = 0;
      else if (m_lc != MINP) m_lc++;
      m_s2 = m_s1; m_s1 = ln;
      m_ph = np;
    end
  end

  always @(negedge clk) if (cmp_on && !done) begin
    chk(dev_en_o == (m_ph == M_ID), "R7 dev_en vs model", dev_en_o, m_ph == M_ID);
    chk(busy_o == (m_ph inside {M_RC, M_RX, M_DR, M_ST}), "R5 busy vs model",
        busy_o, m_ph inside {M_RC, M_RX, M_DR, M_ST});
    chk(hs_drive_o == (m_ph inside {M_DR, M_ST}), "R4 drive vs model",
        hs_drive_o, m_ph inside {M_DR, M_ST});
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    host_en = 1; host_we = 1; host_addr = AW'(a); host_wdata = DW'(d);
    @(negedge clk);
    host_en = 0; host_we = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    host_en = 1; host_we = 0; host_addr = AW'(a);
    @(negedge clk);
    host_en = 0;
    v = host_rdata_o;
  endtask

  task automatic wait_en(output int busy_n);
    busy_n = 0;
    for (int i = 0; i < 500 && !dev_en_o; i++) begin
      if (busy_o) busy_n++;
      @(negedge clk);
    end
  endtask

  function automatic int p1(input int a); return (a * 7 + 3) & 8'hFF; endfunction
  function automatic int p2(input int a); return (a * 13 + 90) & 8'hFF; endfunction

  initial begin
    int n, v, t;
    bit seen;
    cyc(3);
    cmp_on = 1;
    chk(!dev_en_o && !busy_o && !hs_drive_o, "R1 reset outputs", {dev_en_o, busy_o, hs_drive_o}, 0);
    rst = 0;
    cyc(10);
    chk(!dev_en_o && !busy_o, "R1 waits for supply", {dev_en_o, busy_o}, 0);

    sup_ok = 1;
    wait_en(n);
    chk(n == RCL_LIM, "R2 recall busy length", n, RCL_LIM);
    chk(n <= RCL_LIM, "R11 recall bound", n, RCL_LIM);

    for (int a = 0; a < DEPTH; a++) wr(a, p1(a));
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      chk(v == p1(a), "R12 read back", v, p1(a));
    end

    // automatic store with a host access that never finishes
    @(negedge clk);
    host_busy = 1; sup_low = 1; sup_ok = 0;
    @(negedge clk);
    chk(busy_o && hs_drive_o && !dev_en_o, "R3 store entry", {busy_o, hs_drive_o, dev_en_o}, 6);
    n = 0;
    while (hs_drive_o && n < 200) begin n++; @(negedge clk); end
    chk(n == STORE_LIM, "R5 drain plus copy length", n, STORE_LIM);
    chk(n <= STORE_LIM, "R11 store bound", n, STORE_LIM);
    chk(!busy_o, "R4 drive released at end", busy_o, 0);
    cyc(10);
    chk(!dev_en_o, "R7 low supply waits for recall", dev_en_o, 0);
    sup_low = 0; host_busy = 0; sup_ok = 1;
    wait_en(n);
    chk(n == RCL_LIM, "R2 recall after low supply", n, RCL_LIM);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      chk(v == p1(a), "R10 recall returns stored data", v, p1(a));
    end

    // short pulse ignored
    @(negedge clk); ext_low = 1;
    cyc(MINP - 1);
    ext_low = 0;
    seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy_o) seen = 1; end
    chk(!seen && dev_en_o, "R6 short pulse ignored", seen, 0);

    for (int a = 0; a < DEPTH; a++) wr(a, p2(a));

    // hardware store with the line held low across the whole store
    @(negedge clk); ext_low = 1;
    t = 0;
    while (!busy_o && t < 50) begin t++; @(negedge clk); end
    chk(t <= MINP + 3, "R6 busy after request", t, MINP + 3);
    wr(0, 8'hEE);
    cyc(40);
    chk(!dev_en_o && !busy_o && !hs_drive_o, "R7 disabled while line low",
        {dev_en_o, busy_o, hs_drive_o}, 0);
    ext_low = 0;
    wait_en(n);
    chk(dev_en_o == 1, "R7 enabled after line high", dev_en_o, 1);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (busy_o) seen = 1; end
    chk(!seen, "R9 no second store", seen, 0);
    rd(0, v);
    chk(v == p2(0), "R8 write while disabled dropped", v, p2(0));

    // overwrite, then recall twice through reset: shadow must be untouched
    for (int a = 0; a < DEPTH; a++) wr(a, a + 100);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); rst = 1;
      cyc(2);
      rst = 0;
      wait_en(n);
      for (int a = 0; a < DEPTH; a++) begin
        rd(a, v);
        chk(v == p2(a), "R10 shadow unchanged by recall", v, p2(a));
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule